// File: doc/BRIEF.md
# Layered Min-Sum LDPC Decoder Core

This block decodes one quasi-cyclic LDPC codeword of 256 coded bits and returns the 32 information bits. Each of the 256 channel values is a signed 6-bit log-likelihood ratio. A positive value favours a 0 bit. A pulse on `start_i` copies the whole LLR vector into an internal belief store. The core then runs iterations of layered min-sum message passing over a 7x8 base matrix of 32x32 circulants. The base matrix is a constant. Each row of the base matrix forms one layer. An entry marked unconnected (shift -1) adds no edges.

Each iteration makes a read pass and a write pass for each of the 7 layers. A syndrome state follows, which counts the unsatisfied parity checks into a register. A syndrome-done state then makes the stop decision from that registered count. Decoding stops when the iteration limit is reached. With early termination enabled, it also stops as soon as the count is zero. The count of completed iterations, the syndrome weight, the converged flag and the hard decisions of coded bits 0..31 stay on the outputs until the next accepted start.

Top module: `ldpc_decoder_core`

## Requirements
- R1: After reset `busy_o`, `converged_o`, `iter_used_o` and `syn_wt_o` are all zero.
- R2: A start is taken only while the core is idle. `busy_o` rises in the cycle after the accepting edge and stays high until decoding ends. A start seen while busy has no effect. If start is held high, the next run begins one idle cycle after the previous run ends.
- R3: When every LLR is +31 (the all-zero codeword), decoding with early termination stops after 1 iteration with `converged_o`=1, `syn_wt_o`=0 and `decoded_o`=0.
- R4: The hard decision is 1 for a negative belief and 0 otherwise. Every base row has an even number of connected circulants, so the all-ones word is a codeword. With every LLR at -32, decoding converges in 1 iteration with `decoded_o`=32'hFFFFFFFF.
- R5: All LLRs at +31 except two bits (index 10 and index 200) at -10 is corrected in 1 iteration, giving `decoded_o`=0 and `converged_o`=1.
- R6: `syn_wt_o` equals the number of unsatisfied checks. Unconnected circulants add no checks. If all LLRs are 0 and a single bit is -1, messages stay zero and the weight equals that bit's column degree: 4 for base columns 0-5 and 3 for columns 6-7. Bit v lies in column v/32. In that case `converged_o`=0.
- R7: A nonzero `max_iter_i` from 1 to 31 is the iteration limit. A word that never converges uses exactly that many iterations.
- R8: `max_iter_i`=0 selects the default limit of 10 iterations.
- R9: With `early_term_i`=0 the core runs the full limit even when the syndrome is zero. It still ends with `converged_o`=1.
- R10: Each iteration takes 16 busy cycles: a read and a write cycle for each of 7 layers, then syndrome and syndrome-done. The stop decision uses the syndrome registered in that same iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only when idle |
| early_term_i | input | 1 | Stop when the syndrome is zero (sampled at start) |
| max_iter_i | input | 5 | Iteration limit, 0 selects the default (sampled at start) |
| llr_i | input | 1536 | 256 signed 6-bit LLRs, bit i at [6i+5:6i] |
| busy_o | output | 1 | Decoding in progress |
| converged_o | output | 1 | Last run ended with a zero syndrome |
| iter_used_o | output | 5 | Iterations completed in the current or last run |
| syn_wt_o | output | 8 | Unsatisfied checks at the last syndrome evaluation |
| decoded_o | output | 32 | Hard decisions of coded bits 0..31 |

## Verification
A start request can arrive in the same cycle that the syndrome-done state retires a run. That request must not be lost, and it must not extend the old run. The bench holds `start_i` high across the end of a run. It expects `busy_o` to drop for exactly one sampled cycle and the second run to last the full 16 cycles. A separate pulse in the middle of a run must leave the run length and the later idle state unchanged. The early-exit decision is also judged against the exact busy-cycle count. A decision made on the previous iteration's syndrome would shift that count by 16 cycles.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;
  localparam int MB   = 7;    // layers (base rows)
  localparam int NB   = 8;    // base columns
  localparam int Z    = 32;   // circulant size
  localparam int N    = NB * Z;
  localparam int M    = MB * Z;
  localparam int K    = 32;
  localparam int BW   = 8;    // belief / message width
  localparam int MW   = BW - 1;
  localparam int CW   = $clog2(NB);
  localparam int LW   = $clog2(MB);
  localparam int WT_W = $clog2(M + 1);

  // -1 = no circulant; every row has even weight
  localparam int SHIFT [MB][NB] = '{
    '{ 5, -1, 12, -1,  0, -1, 20, -1},
    '{-1,  7, -1,  3, -1, 17, -1,  0},
    '{ 9, 14, -1, -1, 28,  1, -1, -1},
    '{-1, -1, 22, 30, -1, -1, 11,  6},
    '{18, -1, -1, 25,  8, -1, -1, 13},
    '{-1, 27,  2, -1, -1, 19,  4, -1},
    '{31, 10, 15, 21, 26, 24, -1, -1}
  };

  typedef struct packed {
    logic [MW-1:0] min1;
    logic [MW-1:0] min2;
    logic [CW-1:0] idx;
    logic [NB-1:0] neg;
  } chk_rec_t;

  function automatic logic signed [BW-1:0] sat_add(input logic signed [BW-1:0] a,
                                                   input logic signed [BW-1:0] b);
    logic signed [BW:0] s;
    s = $signed({a[BW-1], a}) + $signed({b[BW-1], b});
    if (s[BW] != s[BW-1]) return s[BW] ? {1'b1, {MW{1'b0}}} : {1'b0, {MW{1'b1}}};
    return s[BW-1:0];
  endfunction

  function automatic logic signed [BW-1:0] c2v_of(input chk_rec_t rec, input int c);
    logic [MW-1:0] mag;
    logic          s;
    mag = (rec.idx == c[CW-1:0]) ? rec.min2 : rec.min1;
    s   = (^rec.neg) ^ rec.neg[c];
    return s ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  endfunction
endpackage

// File: rtl/ldpc_check_node.sv
module ldpc_check_node
  import ldpc_pkg::*;
(
  input  logic signed [BW-1:0] v2c_i [NB],
  input  logic [NB-1:0]        conn_i,
  output chk_rec_t             rec_o
);
  logic [BW-1:0] a [NB];
  logic [MW-1:0] mag [NB];

  always_comb begin
    rec_o = '{min1: '1, min2: '1, idx: '0, neg: '0};
    for (int c = 0; c < NB; c++) begin
      a[c]   = v2c_i[c][BW-1] ? -v2c_i[c] : v2c_i[c];
      mag[c] = a[c][BW-1] ? {MW{1'b1}} : a[c][MW-1:0];
      if (conn_i[c]) begin
        rec_o.neg[c] = v2c_i[c][BW-1];
        if (mag[c] < rec_o.min1) begin
          rec_o.min2 = rec_o.min1;
          rec_o.min1 = mag[c];
          rec_o.idx  = c[CW-1:0];
        end else if (mag[c] < rec_o.min2) begin
          rec_o.min2 = mag[c];
        end
      end
    end
  end

  always_comb
    assert_min_order_R6: assert (rec_o.min1 <= rec_o.min2);
endmodule

// File: rtl/ldpc_syndrome.sv
module ldpc_syndrome
  import ldpc_pkg::*;
(
  input  logic [N-1:0]    hard_i,
  output logic [WT_W-1:0] weight_o
);
  logic p;

  always_comb begin
    weight_o = '0;
    for (int l = 0; l < MB; l++) begin
      for (int r = 0; r < Z; r++) begin
        p = 1'b0;
        for (int c = 0; c < NB; c++)
          if (SHIFT[l][c] >= 0) p = p ^ hard_i[c*Z + (r + SHIFT[l][c]) % Z];
        weight_o = weight_o + {{(WT_W-1){1'b0}}, p};
      end
    end
  end
endmodule

// File: rtl/ldpc_decoder_core.sv
module ldpc_decoder_core
  import ldpc_pkg::*;
#(
  parameter int LLR_W    = 6,
  parameter int IT_W     = 5,
  parameter int DEF_ITER = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               early_term_i,
  input  logic [IT_W-1:0]    max_iter_i,
  input  logic [N*LLR_W-1:0] llr_i,
  output logic               busy_o,
  output logic               converged_o,
  output logic [IT_W-1:0]    iter_used_o,
  output logic [WT_W-1:0]    syn_wt_o,
  output logic [K-1:0]       decoded_o
);
  typedef enum logic [2:0] {S_IDLE, S_LREAD, S_LWRITE, S_SYN, S_SYN_DONE} state_t;

  state_t               state_q;
  logic [LW-1:0]        layer_q;
  logic [IT_W-1:0]      iter_q, lim_q;
  logic                 et_q, conv_q;
  logic [WT_W-1:0]      wt_q, wt_d;
  logic signed [BW-1:0] belief_q [N];
  chk_rec_t             rec_q    [MB][Z];
  logic signed [BW-1:0] v2c_d    [Z][NB];
  logic signed [BW-1:0] v2c_q    [Z][NB];
  chk_rec_t             rec_d    [Z];
  chk_rec_t             new_rec_q[Z];
  logic signed [BW-1:0] bel_wr   [N];
  logic [N-1:0]         wr_en, hard;
  logic [NB-1:0]        conn;

  // layer read: subtract last message of this layer, skip unconnected columns
  always_comb begin
    for (int c = 0; c < NB; c++) conn[c] = SHIFT[layer_q][c] >= 0;
    for (int r = 0; r < Z; r++)
      for (int c = 0; c < NB; c++) begin
        v2c_d[r][c] = '0;
        if (SHIFT[layer_q][c] >= 0)
          v2c_d[r][c] = sat_add(belief_q[c*Z + (r + SHIFT[layer_q][c]) % Z],
                                -c2v_of(rec_q[layer_q][r], c));
      end
  end

  for (genvar r = 0; r < Z; r++) begin : g_cn
    ldpc_check_node u_cn (.v2c_i(v2c_d[r]), .conn_i(conn), .rec_o(rec_d[r]));
  end

  // layer write: circulant column p is fed by row (p - shift) mod Z
  always_comb begin
    for (int c = 0; c < NB; c++)
      for (int p = 0; p < Z; p++) begin
        wr_en[c*Z+p]  = 1'b0;
        bel_wr[c*Z+p] = belief_q[c*Z+p];
        if (SHIFT[layer_q][c] >= 0) begin
          wr_en[c*Z+p]  = 1'b1;
          bel_wr[c*Z+p] = sat_add(v2c_q[(p - SHIFT[layer_q][c] + Z) % Z][c],
                                  c2v_of(new_rec_q[(p - SHIFT[layer_q][c] + Z) % Z], c));
        end
      end
  end

  always_comb
    for (int i = 0; i < N; i++) hard[i] = belief_q[i][BW-1];

  ldpc_syndrome u_syn (.hard_i(hard), .weight_o(wt_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      layer_q <= '0;
      iter_q  <= '0;
      lim_q   <= '0;
      et_q    <= 1'b0;
      conv_q  <= 1'b0;
      wt_q    <= '0;
      for (int i = 0; i < N; i++) belief_q[i] <= '0;
      for (int l = 0; l < MB; l++) rec_q[l] <= '{default: '0};
      v2c_q     <= '{default: '{default: '0}};
      new_rec_q <= '{default: '0};
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          for (int i = 0; i < N; i++)
            belief_q[i] <= {{(BW-LLR_W){llr_i[i*LLR_W+LLR_W-1]}}, llr_i[i*LLR_W +: LLR_W]};
          for (int l = 0; l < MB; l++) rec_q[l] <= '{default: '0};
          lim_q   <= (max_iter_i == '0) ? DEF_ITER[IT_W-1:0] : max_iter_i;
          et_q    <= early_term_i;
          iter_q  <= '0;
          conv_q  <= 1'b0;
          wt_q    <= '0;
          layer_q <= '0;
          state_q <= S_LREAD;
        end
        S_LREAD: begin
          v2c_q     <= v2c_d;
          new_rec_q <= rec_d;
          state_q   <= S_LWRITE;
        end
        S_LWRITE: begin
          for (int i = 0; i < N; i++) if (wr_en[i]) belief_q[i] <= bel_wr[i];
          rec_q[layer_q] <= new_rec_q;
          if (layer_q == LW'(MB - 1)) state_q <= S_SYN;
          else begin
            layer_q <= layer_q + 1'b1;
            state_q <= S_LREAD;
          end
        end
        S_SYN: begin
          wt_q    <= wt_d;
          iter_q  <= iter_q + 1'b1;
          state_q <= S_SYN_DONE;
        end
        S_SYN_DONE: begin
          if ((et_q && wt_q == '0) || iter_q >= lim_q) begin
            conv_q  <= (wt_q == '0);
            state_q <= S_IDLE;
          end else begin
            layer_q <= '0;
            state_q <= S_LREAD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign converged_o = conv_q;
  assign iter_used_o = iter_q;
  assign syn_wt_o    = wt_q;
  assign decoded_o   = hard[K-1:0];

  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && iter_used_o == '0));
  assert_exit_from_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(state_q == S_SYN_DONE));
  assert_early_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SYN_DONE && et_q && wt_q == '0) |=> (!busy_o && converged_o));
  assert_conv_zero_wt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    converged_o |-> (syn_wt_o == '0));
  assert_iter_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_used_o <= lim_q);
endmodule

// File: tb/ldpc_decoder_core_tb.sv
module ldpc_decoder_core_tb;
  localparam int NBIT = 256;
  localparam int QW   = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              et = 1'b1;
  logic [4:0]        mx = '0;
  logic [NBIT*QW-1:0] llr = '0;
  logic              busy, conv;
  logic [4:0]        iter;
  logic [7:0]        wt;
  logic [31:0]       dec;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ldpc_decoder_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .early_term_i(et),
    .max_iter_i(mx), .llr_i(llr), .busy_o(busy), .converged_o(conv),
    .iter_used_o(iter), .syn_wt_o(wt), .decoded_o(dec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < NBIT; i++) llr[i*QW +: QW] = v[QW-1:0];
  endtask

  task automatic set_bit(input int idx, input int v);
    llr[idx*QW +: QW] = v[QW-1:0];
  endtask

  task automatic run(input logic e, input logic [4:0] m, output int cyc);
    @(negedge clk);
    et = e; mx = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 2000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 converged", {31'b0, conv}, 0);
    check("R1 iter", {27'b0, iter}, 0);
    check("R1 weight", {24'b0, wt}, 0);
  endtask

  task automatic t_zero_cw;
    int c;
    fill(31);
    run(1'b1, 5'd0, c);
    check("R3 converged", {31'b0, conv}, 1);
    check("R3 iter", {27'b0, iter}, 1);
    check("R3 weight", {24'b0, wt}, 0);
    check("R3 decoded", dec, 0);
    check("R10 cycles one iteration", c, 16);
  endtask

  task automatic t_ones_cw;
    int c;
    fill(-32);
    run(1'b1, 5'd0, c);
    check("R4 decoded", dec, 32'hFFFF_FFFF);
    check("R4 converged", {31'b0, conv}, 1);
    check("R4 iter", {27'b0, iter}, 1);
  endtask

  task automatic t_flip;
    int c;
    fill(31);
    set_bit(10, -10);
    set_bit(200, -10);
    run(1'b1, 5'd0, c);
    check("R5 decoded", dec, 0);
    check("R5 converged", {31'b0, conv}, 1);
    check("R5 iter", {27'b0, iter}, 1);
  endtask

  task automatic t_stuck;
    int c;
    fill(0);
    set_bit(5, -1);
    run(1'b1, 5'd3, c);
    check("R6 weight col0", {24'b0, wt}, 4);
    check("R6 not converged", {31'b0, conv}, 0);
    check("R4 decoded single one", dec, 32'h20);
    check("R7 iter limit 3", {27'b0, iter}, 3);
    check("R10 cycles three iterations", c, 48);
    fill(0);
    set_bit(227, -1);
    run(1'b1, 5'd1, c);
    check("R6 weight col7", {24'b0, wt}, 3);
    check("R7 iter limit 1", {27'b0, iter}, 1);
    check("R6 decoded zero", dec, 0);
  endtask

  task automatic t_limits;
    int c;
    fill(0);
    set_bit(40, -1);
    run(1'b1, 5'd31, c);
    check("R7 iter limit 31", {27'b0, iter}, 31);
    check("R7 cycles 31", c, 31*16);
    check("R6 weight col1", {24'b0, wt}, 4);
    run(1'b1, 5'd0, c);
    check("R8 default limit", {27'b0, iter}, 10);
    check("R8 not converged", {31'b0, conv}, 0);
  endtask

  task automatic t_no_et;
    int c;
    fill(31);
    run(1'b0, 5'd4, c);
    check("R9 iter full", {27'b0, iter}, 4);
    check("R9 converged", {31'b0, conv}, 1);
    check("R9 weight", {24'b0, wt}, 0);
    check("R9 cycles", c, 64);
  endtask

  task automatic t_busy_start;
    int c;
    int gap;
    fill(31);
    @(negedge clk);
    et = 1'b0; mx = 5'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (busy && c < 2000) begin
      c++;
      start = (c == 5);
      @(negedge clk);
    end
    start = 1'b0;
    check("R2 start while busy ignored, run length", c, 32);
    repeat (5) @(negedge clk);
    check("R2 idle after ignored start", {31'b0, busy}, 0);
    check("R2 iter kept", {27'b0, iter}, 2);
    // start held across the end of a run
    @(negedge clk);
    et = 1'b1; mx = 5'd0; start = 1'b1;
    @(negedge clk);
    c = 0;
    while (busy && c < 2000) begin
      c++;
      @(negedge clk);
    end
    check("R2 held start first run", c, 16);
    gap = 0;
    while (!busy && gap < 10) begin
      gap++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R2 idle gap", gap, 1);
    c = 0;
    while (busy && c < 2000) begin
      c++;
      @(negedge clk);
    end
    check("R2 held start second run", c, 16);
    check("R2 second run converged", {31'b0, conv}, 1);
  endtask

  initial begin
    #1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_cw();
    t_ones_cw();
    t_flip();
    t_stuck();
    t_limits();
    t_no_et();
    t_busy_start();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule